// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies a signed two's-complement multiplicand by a signed two's-complement multiplier over several clock cycles. A one-cycle `start_i` captures both operands. From then on the block makes one recoded step per clock. Each step adds the multiplicand, subtracts it, or leaves the partial result alone, and then shifts one place right. When the last step is done, the block raises `done_o` for one cycle. The full-width signed product appears on `product_o` at the same time.

One working register holds three things: the partial product in its upper part, the unconsumed multiplier bits below that, and a single history bit at the bottom. Two constant words are formed when the operands are loaded. One adds the multiplicand at the top of the register. The other subtracts it. Every word carries one extra sign bit above the multiplicand field. This guard bit keeps the negated multiplicand in range for every input, including the most negative one.

Top module: `booth_seq_mult`

## Requirements
- R1: After an accepted start, `product_o` equals the signed product of `mcand_i` and `mplr_i`, which are sampled on that start edge. The product is MCAND_W+MPLR_W bits wide, in two's complement. Example: with 8-bit operands, 3 × -4 gives 16'hFFF4.
- R2: `done_o` is high in the cycle that begins exactly MPLR_W clock edges after the edge that accepted `start_i`.
- R3: `done_o` is high for exactly one cycle for each accepted start.
- R4: A `start_i` that arrives while `busy_o` is high has no effect. The operation in progress keeps its operands, its result and its timing.
- R5: `product_o` changes only in the cycle where `done_o` is high. It holds its value at all other times, whatever the operand inputs do.
- R6: Operands at the most negative value give correct products. This covers the most negative value times itself, times the most positive value, and times one.
- R7: While `rst_ni` is low, `busy_o`, `done_o` and `product_o` are all zero. If reset arrives in the middle of an operation, that operation is abandoned.
- R8: `busy_o` goes high in the cycle after an accepted start. It stays high through the final step and drops in the same cycle that `done_o` rises. A start is accepted only when `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| mcand_i | input | MCAND_W | Signed multiplicand |
| mplr_i | input | MPLR_W | Signed multiplier |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | MCAND_W+MPLR_W | Signed product, held between completions |

## Verification
The hardest case to reach from the ports is the guard bit actually being needed. That only happens when the most negative multiplicand is subtracted and the partial sum would otherwise wrap. The vector table therefore pairs the most negative value with itself, with the most positive value, and with plus and minus one. Those pairings make both the add word and the subtract word reach the register's extreme values.

A second hard case is a start pulse that arrives halfway through an operation. The bench issues a start with different operands while the block is busy. It then checks that the completion timing and the product still belong to the first operation. A final case is a reset during an operation: the bench checks that the block then returns to its cleared state.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;
  typedef enum logic [1:0] {
    BOOTH_HOLD = 2'b00,
    BOOTH_ADD  = 2'b01,
    BOOTH_SUB  = 2'b10
  } booth_op_e;

  function automatic booth_op_e booth_decode(input logic [1:0] pair);
    case (pair)
      2'b01:   return BOOTH_ADD;
      2'b10:   return BOOTH_SUB;
      default: return BOOTH_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/booth_operand_prep.sv
module booth_operand_prep #(
  parameter int MCAND_W = 8,
  parameter int MPLR_W  = 8,
  localparam int HI_W   = MCAND_W + 1,
  localparam int P_W    = HI_W + MPLR_W + 1
) (
  input  logic [MCAND_W-1:0] mcand_i,
  input  logic [MPLR_W-1:0]  mplr_i,
  output logic [P_W-1:0]     add_word_o,
  output logic [P_W-1:0]     sub_word_o,
  output logic [P_W-1:0]     p_init_o
);
  logic [HI_W-1:0] m_ext;
  logic [HI_W-1:0] m_neg;

  // guard bit: sign-extend before negating
  assign m_ext = {mcand_i[MCAND_W-1], mcand_i};
  assign m_neg = ~m_ext + HI_W'(1);

  assign add_word_o = {m_ext, {(MPLR_W+1){1'b0}}};
  assign sub_word_o = {m_neg, {(MPLR_W+1){1'b0}}};
  assign p_init_o   = {{HI_W{1'b0}}, mplr_i, 1'b0};
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_mult_pkg::*;
#(
  parameter int P_W = 18
) (
  input  logic [P_W-1:0] p_i,
  input  logic [P_W-1:0] add_word_i,
  input  logic [P_W-1:0] sub_word_i,
  output logic [P_W-1:0] p_nxt_o
);
  logic [P_W-1:0] sum;

  always_comb begin
    unique case (booth_decode(p_i[1:0]))
      BOOTH_ADD: sum = p_i + add_word_i;
      BOOTH_SUB: sum = p_i + sub_word_i;
      default:   sum = p_i;
    endcase
  end

  assign p_nxt_o = {sum[P_W-1], sum[P_W-1:1]};
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int STEPS = 8,
  localparam int CNT_W = (STEPS < 2) ? 1 : $clog2(STEPS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign load_o = start_i && !busy_q;
  assign last_o = busy_q && (cnt_q == CNT_W'(STEPS - 1));
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        busy_q <= !last_o;
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_done_not_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= CNT_W'(STEPS - 1)));

  p_start_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last_o) |=> (busy_q && cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int MCAND_W = 8,
  parameter int MPLR_W  = 8,
  localparam int PROD_W = MCAND_W + MPLR_W,
  localparam int P_W    = PROD_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [MCAND_W-1:0] mcand_i,
  input  logic [MPLR_W-1:0]  mplr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [PROD_W-1:0]  product_o
);
  logic [P_W-1:0] add_init, sub_init, p_init;
  logic [P_W-1:0] add_q, sub_q, p_q, p_nxt;
  logic [PROD_W-1:0] product_q;
  logic load, last;

  booth_operand_prep #(.MCAND_W(MCAND_W), .MPLR_W(MPLR_W)) prep_i (
    .mcand_i    (mcand_i),
    .mplr_i     (mplr_i),
    .add_word_o (add_init),
    .sub_word_o (sub_init),
    .p_init_o   (p_init)
  );

  booth_step #(.P_W(P_W)) step_i (
    .p_i        (p_q),
    .add_word_i (add_q),
    .sub_word_i (sub_q),
    .p_nxt_o    (p_nxt)
  );

  booth_ctrl #(.STEPS(MPLR_W)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .busy_o  (busy_o),
    .last_o  (last),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_q     <= '0;
      sub_q     <= '0;
      p_q       <= '0;
      product_q <= '0;
    end else begin
      if (load) begin
        add_q <= add_init;
        sub_q <= sub_init;
        p_q   <= p_init;
      end else if (busy_o) begin
        p_q <= p_nxt;
      end
      // drop history bit, keep low PROD_W bits of the guarded result
      if (last) product_q <= p_nxt[PROD_W:1];
    end
  end

  assign product_o = product_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(product_o));

  p_guard_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (add_q[P_W-1] == add_q[P_W-2]) && (sub_q[MPLR_W:0] == '0));

  p_done_follows_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/booth_seq_mult_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mult_tb_top;
  localparam int XW = 8;
  localparam int YW = 8;
  localparam int OW = XW + YW;
  localparam int NVEC = 10;
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h03, 8'hFC}, {8'h80, 8'h80}, {8'h80, 8'h7F}, {8'h7F, 8'h7F},
    {8'hFF, 8'hFF}, {8'h00, 8'h55}, {8'h80, 8'h01}, {8'h01, 8'h80},
    {8'hAA, 8'h55}, {8'h80, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [XW-1:0] mcand = '0;
  logic [YW-1:0] mplr = '0;
  logic busy, done;
  logic [OW-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  booth_seq_mult #(.MCAND_W(XW), .MPLR_W(YW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .mcand_i(mcand),
    .mplr_i(mplr), .busy_o(busy), .done_o(done), .product_o(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] ref_mul(input logic [XW-1:0] a, input logic [YW-1:0] b);
    logic signed [OW-1:0] ea, eb;
    ea = $signed({{YW{a[XW-1]}}, a});
    eb = $signed({{XW{b[YW-1]}}, b});
    return OW'(ea * eb);
  endfunction

  // drive start for one cycle, return latency and product at done
  task automatic run_op(input logic [XW-1:0] a, input logic [YW-1:0] b,
                        input int late_start_at, output int lat);
    @(negedge clk);
    mcand = a; mplr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    lat = 0;
    while (!done && lat < 64) begin
      if (lat == late_start_at) begin
        mcand = ~a; mplr = b ^ 8'h5A; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [OW-1:0] held;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(busy == 0 && done == 0 && product == 0, "R7 reset outputs", {busy, done, product}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][15:8], VEC[i][7:0], -1, lat);
      check(lat == YW, "R2 latency", lat, YW);
      check(product == ref_mul(VEC[i][15:8], VEC[i][7:0]),
            (VEC[i][15:8] == 8'h80 || VEC[i][7:0] == 8'h80) ? "R6 most negative product" : "R1 product",
            product, ref_mul(VEC[i][15:8], VEC[i][7:0]));
      check(busy == 0, "R8 busy clear at done", busy, 0);
      held = product;
      @(negedge clk);
      check(done == 0, "R3 done single pulse", done, 0);
      check(product == held, "R5 product held", product, held);
    end

    // R1 documented example
    run_op(8'h03, 8'hFC, -1, lat);
    check(product == 16'hFFF4, "R1 3 x -4", product, 16'hFFF4);

    // R4 start during busy ignored
    run_op(8'h13, 8'hE7, 3, lat);
    check(lat == YW, "R4 latency unchanged", lat, YW);
    check(product == ref_mul(8'h13, 8'hE7), "R4 first operands kept", product, ref_mul(8'h13, 8'hE7));
    @(negedge clk);
    check(busy == 0, "R4 no second operation", busy, 0);

    // R5 inputs change with no start
    held = product;
    mcand = 8'h77; mplr = 8'h99;
    repeat (12) @(negedge clk);
    check(product == held && done == 0, "R5 hold without start", product, held);

    // R7 reset mid-operation
    @(negedge clk);
    mcand = 8'h45; mplr = 8'h23; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(busy == 0 && done == 0 && product == 0, "R7 reset abandons op", {busy, done, product}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (YW + 2) @(negedge clk);
    check(done == 0 && product == 0, "R7 no completion after reset", {done, product}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule